// File: doc/BRIEF.md
# Relative-Jump Program Counter

This block holds the instruction address of a small processor and drives the program-memory address lines with it. On every rising clock edge it moves to a new address. By default that is the next location. A relative jump instead adds a signed 8-bit displacement, which is carried inside the current instruction, to the present address. One form of the relative jump always fires. The other fires only while the zero flag is set. A register jump overwrites the counter with a full 16-bit address formed from two 8-bit general registers.

A single 16-bit adder produces both the step result and the relative-jump result, because its second operand is chosen between the constant one and the sign-extended displacement. The register path skips the adder. Instruction fetch, decoding and the memories are outside this block. The decoder supplies the one-hot jump selects, the displacement field and the two register bytes for the instruction that is executing.

Top module: `pc_relative_jump`

## Requirements
- R1: `rst` is synchronous and active high. When it is sampled high at a rising edge, `pc_addr` becomes 16'h0000 after that edge, whatever the other inputs are.
- R2: When `jump_sel` is 3'b000, each rising edge adds one to `pc_addr`.
- R3: With only `jump_sel[0]` set (unconditional relative jump), the next address is the current address plus `ofs_field` read as a two's-complement value from -128 to +127.
- R4: With only `jump_sel[1]` set (relative jump on zero), the displacement from R3 is added when `zero_flag` is 1. When `zero_flag` is 0 the address advances by one.
- R5: With `jump_sel[2]` set (register jump), the next address is `{hi_byte, lo_byte}`, so `hi_byte` supplies bits [15:8].
- R6: When several selects are set, the register jump wins over the unconditional relative jump, and the unconditional relative jump wins over the conditional one.
- R7: Address arithmetic wraps modulo 2^16. Stepping from 16'hFFFF gives 16'h0000, and a backward jump past zero continues from 16'hFFFF downward.
- R8: `zero_flag` has no effect unless the conditional relative jump is the selected action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ofs_field | input | 8 | Signed displacement taken from the instruction |
| hi_byte | input | 8 | Register byte used as address bits [15:8] for a register jump |
| lo_byte | input | 8 | Register byte used as address bits [7:0] for a register jump |
| zero_flag | input | 1 | Condition for the conditional relative jump |
| jump_sel | input | 3 | One-hot action select: bit0 relative, bit1 relative-if-zero, bit2 register |
| pc_addr | output | 16 | Current program-memory address |

## Verification
Plain stepping is checked across several cycles, and it is repeated with the zero flag high to show that the flag is ignored there. Relative jumps use forward, backward and extreme displacements (+127 and -128). These separate a correct sign extension from zero extension and from a wrong offset width. The conditional jump is run with the flag both high and low. Combined selects with the flag low show the priority order: a conditional-over-unconditional mistake gives +1 instead of the displacement. Register loads near 16'hFFFF and near zero test wrap-around in both directions, and a reset asserted together with a register jump confirms that reset takes precedence.

// File: rtl/pc_pkg.sv
package pc_pkg;

    // bit positions inside the one-hot jump select
    localparam int SEL_W    = 3;
    localparam int SEL_REL  = 0;
    localparam int SEL_COND = 1;
    localparam int SEL_REG  = 2;

    typedef enum logic [1:0] {
        NXT_STEP = 2'd0,
        NXT_REL  = 2'd1,
        NXT_LOAD = 2'd2
    } nxt_kind_e;

    typedef struct packed {
        nxt_kind_e kind;
        logic      use_offset;
    } pc_decision_t;

    // priority: register load, then unconditional relative, then conditional
    function automatic pc_decision_t decide(input logic [SEL_W-1:0] sel,
                                            input logic             zf);
        pc_decision_t d;
        d.kind       = NXT_STEP;
        d.use_offset = 1'b0;
        if (sel[SEL_REG]) begin
            d.kind = NXT_LOAD;
        end else if (sel[SEL_REL]) begin
            d.kind       = NXT_REL;
            d.use_offset = 1'b1;
        end else if (sel[SEL_COND] && zf) begin
            d.kind       = NXT_REL;
            d.use_offset = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/pc_jump_arbiter.sv
module pc_jump_arbiter
    import pc_pkg::*;
(
    input  logic [SEL_W-1:0] jump_sel,
    input  logic             zero_flag,
    output pc_decision_t     decision
);

    always_comb begin
        decision = decide(jump_sel, zero_flag);
    end

    always_comb begin
        if (jump_sel == '0) begin
            p_idle_steps_r2: assert (decision.kind == NXT_STEP && !decision.use_offset);
        end
    end

endmodule

// File: rtl/pc_step_adder.sv
module pc_step_adder #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 8
) (
    input  logic [PC_W-1:0]  cur,
    input  logic [OFS_W-1:0] ofs,
    input  logic             use_offset,
    output logic [PC_W-1:0]  sum
);

    localparam int EXT_W = PC_W - OFS_W;

    logic [PC_W-1:0] ofs_ext;
    logic [PC_W-1:0] operand;

    generate
        if (EXT_W > 0) begin : g_extend
            assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        end else begin : g_trunc
            assign ofs_ext = ofs[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        operand = use_offset ? ofs_ext : PC_W'(1);
        sum     = cur + operand;   // carry out dropped: modulo 2^PC_W
    end

endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg
    import pc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  nxt_kind_e       kind,
    input  logic [PC_W-1:0] sum,
    input  logic [PC_W-1:0] load_val,
    output logic [PC_W-1:0] q
);

    logic [PC_W-1:0] d;

    always_comb begin
        unique case (kind)
            NXT_LOAD: d = load_val;
            default:  d = sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/pc_relative_jump.sv
module pc_relative_jump
    import pc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int OFS_W  = 8,
    localparam int HALF_W = PC_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  ofs_field,
    input  logic [HALF_W-1:0] hi_byte,
    input  logic [HALF_W-1:0] lo_byte,
    input  logic              zero_flag,
    input  logic [SEL_W-1:0]  jump_sel,
    output logic [PC_W-1:0]   pc_addr
);

    localparam int EXT_W = PC_W - OFS_W;

    pc_decision_t    dec;
    logic [PC_W-1:0] sum;
    logic [PC_W-1:0] pc_q;

    pc_jump_arbiter u_arb (
        .jump_sel  (jump_sel),
        .zero_flag (zero_flag),
        .decision  (dec)
    );

    pc_step_adder #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
        .cur        (pc_q),
        .ofs        (ofs_field),
        .use_offset (dec.use_offset),
        .sum        (sum)
    );

    pc_state_reg #(.PC_W(PC_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .kind     (dec.kind),
        .sum      (sum),
        .load_val ({hi_byte, lo_byte}),
        .q        (pc_q)
    );

    assign pc_addr = pc_q;

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_q == '0);

    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        jump_sel == '0 |=> pc_q == $past(pc_q) + PC_W'(1));

    p_rel_jump_r3: assert property (@(posedge clk) disable iff (rst)
        jump_sel == 3'b001 |=>
        pc_q == $past(pc_q) + {{EXT_W{$past(ofs_field[OFS_W-1])}}, $past(ofs_field)});

    p_cond_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (jump_sel == 3'b010 && zero_flag) |=>
        pc_q == $past(pc_q) + {{EXT_W{$past(ofs_field[OFS_W-1])}}, $past(ofs_field)});

    p_cond_skip_r4: assert property (@(posedge clk) disable iff (rst)
        (jump_sel == 3'b010 && !zero_flag) |=> pc_q == $past(pc_q) + PC_W'(1));

    p_reg_load_r5: assert property (@(posedge clk) disable iff (rst)
        jump_sel[SEL_REG] |=> pc_q == {$past(hi_byte), $past(lo_byte)});

    p_rel_beats_cond_r6: assert property (@(posedge clk) disable iff (rst)
        (jump_sel == 3'b011 && !zero_flag) |=>
        pc_q == $past(pc_q) + {{EXT_W{$past(ofs_field[OFS_W-1])}}, $past(ofs_field)});

endmodule

// File: tb/sim_pc_relative_jump.sv
module sim_pc_relative_jump;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ofs_field = '0;
    logic [7:0]  hi_byte = '0;
    logic [7:0]  lo_byte = '0;
    logic        zero_flag = 1'b0;
    logic [2:0]  jump_sel = '0;
    logic [15:0] pc_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_relative_jump u0 (
        .clk       (clk),
        .rst       (rst),
        .ofs_field (ofs_field),
        .hi_byte   (hi_byte),
        .lo_byte   (lo_byte),
        .zero_flag (zero_flag),
        .jump_sel  (jump_sel),
        .pc_addr   (pc_addr)
    );

    task automatic check(input logic [15:0] exp, input string req);
        checks++;
        if (pc_addr !== exp) begin
            errors++;
            $display("FAIL %s: pc_addr=%h expected=%h", req, pc_addr, exp);
        end
    endtask

    // inputs change at the falling edge, result sampled at the next falling edge
    task automatic cycle(input logic [2:0] sel, input logic [7:0] ofs,
                         input logic zf, input logic [15:0] exp, input string req);
        jump_sel  = sel;
        ofs_field = ofs;
        zero_flag = zf;
        @(posedge clk);
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic load(input logic [15:0] addr, input string req);
        hi_byte = addr[15:8];
        lo_byte = addr[7:0];
        cycle(3'b100, 8'h00, 1'b0, addr, req);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(16'h0000, "R1");
        @(negedge clk);
        check(16'h0000, "R1");
        rst = 1'b0;
    endtask

    task automatic t_step;
        cycle(3'b000, 8'h55, 1'b0, 16'h0001, "R2");
        cycle(3'b000, 8'h55, 1'b0, 16'h0002, "R2");
        cycle(3'b000, 8'hAA, 1'b1, 16'h0003, "R8");
        cycle(3'b000, 8'hFF, 1'b1, 16'h0004, "R8");
    endtask

    task automatic t_rel;
        load(16'h1000, "R5");
        cycle(3'b001, 8'h05, 1'b0, 16'h1005, "R3");
        cycle(3'b001, 8'hFD, 1'b0, 16'h1002, "R3");
        cycle(3'b001, 8'h7F, 1'b1, 16'h1081, "R3");
        cycle(3'b001, 8'h80, 1'b0, 16'h1001, "R3");
    endtask

    task automatic t_cond;
        load(16'h2000, "R5");
        cycle(3'b010, 8'h10, 1'b1, 16'h2010, "R4");
        cycle(3'b010, 8'h10, 1'b0, 16'h2011, "R4");
        cycle(3'b010, 8'hF0, 1'b1, 16'h2001, "R4");
    endtask

    task automatic t_regload;
        load(16'h1234, "R5");
        load(16'hABCD, "R5");
    endtask

    task automatic t_priority;
        load(16'h3000, "R5");
        hi_byte = 8'h45; lo_byte = 8'h67;
        cycle(3'b111, 8'h20, 1'b1, 16'h4567, "R6");
        cycle(3'b011, 8'h08, 1'b0, 16'h456F, "R6");
        hi_byte = 8'h00; lo_byte = 8'h40;
        cycle(3'b101, 8'h08, 1'b0, 16'h0040, "R6");
    endtask

    task automatic t_wrap;
        load(16'hFFFF, "R5");
        cycle(3'b000, 8'h00, 1'b0, 16'h0000, "R7");
        load(16'h0002, "R5");
        cycle(3'b001, 8'hFC, 1'b0, 16'hFFFE, "R7");
        cycle(3'b001, 8'h05, 1'b0, 16'h0003, "R7");
    endtask

    task automatic t_midreset;
        load(16'h5555, "R5");
        rst = 1'b1;
        hi_byte = 8'h77; lo_byte = 8'h77;
        cycle(3'b100, 8'h00, 1'b0, 16'h0000, "R1");
        rst = 1'b0;
        cycle(3'b000, 8'h00, 1'b0, 16'h0001, "R1");
    endtask

    initial begin
        t_reset();
        t_step();
        t_rel();
        t_cond();
        t_regload();
        t_priority();
        t_wrap();
        t_midreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule